// File: doc/BRIEF.md
# Folded Neuron Multiply-Accumulate Datapath

This block computes the weighted sum of one perceptron neuron using a fixed bank of M multiplier lanes. A neuron whose fan-in exceeds M is evaluated over several passes. Each pass supplies up to M input/weight pairs, and a lane mask switches off the lanes a short final pass does not fill. The lane products are truncated to an internal fixed-point width and summed by a balanced adder tree. A parameter sets how many of the tree's levels end in a register. On the opening pass of a neuron, the tree sum is added to the neuron's bias. On every later pass it is added to the running accumulator. Control strobes, bias and shift amount travel through the tree pipeline beside the data, so the accumulator selection always lines up with the sum it belongs to.

When the closing pass reaches the accumulator, the new total is shifted left by the layer's power-of-two post-scale. The shift undoes an offline down-scaling of weights and biases that fall outside the unit range. The shifted total is then clamped to the internal word range and registered as the value handed to the activation stage, together with a one-cycle valid strobe. Sequencing of passes and storage of weights are left to the surrounding controller.

Top module: `nfold_neuron_acc`

## Requirements
- R1: Inputs and weights are signed N+1-bit fractions with value word/2^N. Each enabled lane yields floor(x*w / 2^(2N-L)) as a signed L+1-bit value in units of 2^-L.
- R2: The one product that does not fit, x = w = -2^N (that is, -1 times -1), yields the largest positive lane value 2^L-1 instead of wrapping.
- R3: A lane whose bit in the lane mask is 0 contributes zero, whatever its input and weight words hold.
- R4: A pass with the first strobe set loads the accumulator with bias + sum of enabled lane values. The bias is a signed L+1-bit value in the same units as the lane values.
- R5: A pass with the first strobe clear adds its lane sum to the accumulator. The bias presented with such a pass has no effect. Any number of passes is accepted, and idle cycles between passes of one neuron are allowed.
- R6: For a pass with the last strobe set that is sampled at clock edge E, the result and a valid strobe high for exactly one cycle appear after edge E+PIPE. The shift amount used is the one presented with that pass.
- R7: The result is the accumulator total multiplied by 2^shift, saturated to the range [-2^L, 2^L-1].
- R8: Passes without the last strobe raise no valid strobe, and the result output holds its previous value.
- R9: After reset the result is 0 and the valid strobe is low.
- R10: Passes of one neuron may be presented on consecutive clock cycles, and each pass still sees the accumulator updated by the pass before it.
- R11: While the pass-valid input is low, the strobes, data, bias and shift inputs have no effect on the accumulator or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pass_vld_i | input | 1 | A pass is presented this cycle |
| pass_first_i | input | 1 | Opening pass of a neuron: start from the bias |
| pass_last_i | input | 1 | Closing pass of a neuron: produce the result |
| lane_en_i | input | M | Per-lane enable mask |
| x_i | input | M*(N+1) | Lane inputs, lane i at bits [i*(N+1) +: N+1] |
| w_i | input | M*(N+1) | Lane weights, same packing as x_i |
| bias_i | input | L+1 | Neuron bias, signed, units of 2^-L |
| shift_i | input | SHW | Layer post-scale exponent, used with the closing pass |
| sum_o | output | L+1 | Scaled, saturated neuron sum, signed |
| sum_vld_o | output | 1 | sum_o updated this cycle, high for one cycle |

## Verification
A closing pass sampled at edge E makes its result and valid strobe visible after edge E+PIPE, so the bench drops the pass-valid input at the next falling edge and waits PIPE more falling edges before it samples. It then checks the valid strobe once more at the following falling edge to confirm the pulse lasts one cycle. Passes that do not close a neuron, and cycles with pass-valid low, are checked at the same point: the valid strobe must stay low and the result must keep its previous value. Multi-pass neurons are driven both on consecutive cycles and with idle gaps, and the expected total is rebuilt in the bench from the lane formula, the bias and the saturation limits.

// File: rtl/nfold_pkg.sv
package nfold_pkg;

   // control bits that ride the tree pipeline beside the data
   typedef struct packed {
      logic vld;
      logic first;
      logic last;
   } pass_ctl_t;

endpackage

// File: rtl/nfold_lane.sv
module nfold_lane #(
   parameter int N     = 3,
   parameter int L     = 5,
   parameter int ACC_W = 9
) (
   input  logic                    en_i,
   input  logic signed [N:0]       x_i,
   input  logic signed [N:0]       w_i,
   output logic signed [ACC_W-1:0] prod_o
);
   localparam int PW    = 2*N + 2;
   localparam int TRUNC = 2*N - L;
   localparam logic signed [N:0] MINV = {1'b1, {N{1'b0}}};
   localparam logic signed [L:0] TOPV = {1'b0, {L{1'b1}}};

   logic signed [PW-1:0] full;
   logic                 both_min;
   logic signed [L:0]    trunc_v;

   assign full     = PW'(x_i) * PW'(w_i);
   assign both_min = (x_i == MINV) && (w_i == MINV);
   assign trunc_v  = both_min ? TOPV : (L+1)'(full >>> TRUNC);
   assign prod_o   = en_i ? ACC_W'(trunc_v) : '0;

   always_comb begin
      if (en_i && (x_i != '0) && (w_i != '0)) begin
         if (x_i[N] != w_i[N]) begin
            assert_prod_sign_R1: assert (prod_o < 0)
               else $error("mixed-sign lane product is not negative");
         end else begin
            assert_prod_pos_R2: assert (prod_o >= 0)
               else $error("same-sign lane product wrapped negative");
         end
      end
   end
endmodule

// File: rtl/nfold_tree.sv
module nfold_tree #(
   parameter int M     = 4,
   parameter int ACC_W = 9,
   parameter int PIPE  = 1,
   parameter int SBW   = 11
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [ACC_W-1:0] prod_i [M],
   input  logic [SBW-1:0]          side_i,
   output logic signed [ACC_W-1:0] sum_o,
   output logic [SBW-1:0]          side_o
);
   localparam int LEVELS = $clog2(M);

   // adder tree, registers on the last PIPE levels
   if (LEVELS == 0) begin : g_flat
      assign sum_o = prod_i[0];
   end else begin : g_tree
      for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
         localparam int CNT = M >> (lv + 1);
         logic signed [ACC_W-1:0] s [CNT];
         logic signed [ACC_W-1:0] q [CNT];
         for (genvar i = 0; i < CNT; i++) begin : g_add
            if (lv == 0) begin : g_leaf
               assign s[i] = prod_i[2*i] + prod_i[2*i+1];
            end else begin : g_inner
               assign s[i] = g_lvl[lv-1].q[2*i] + g_lvl[lv-1].q[2*i+1];
            end
         end
         if (lv >= LEVELS - PIPE) begin : g_reg
            always_ff @(posedge clk) begin
               if (rst) begin
                  for (int i = 0; i < CNT; i++) q[i] <= '0;
               end else begin
                  for (int i = 0; i < CNT; i++) q[i] <= s[i];
               end
            end
         end else begin : g_wire
            assign q = s;
         end
      end
      assign sum_o = g_lvl[LEVELS-1].q[0];
   end

   // sideband delay matching the tree registers
   if (PIPE == 0) begin : g_side_wire
      assign side_o = side_i;
   end else begin : g_side_pipe
      logic [SBW-1:0] st [PIPE];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int k = 0; k < PIPE; k++) st[k] <= '0;
         end else begin
            st[0] <= side_i;
            for (int k = 1; k < PIPE; k++) st[k] <= st[k-1];
         end
      end
      assign side_o = st[PIPE-1];
   end
endmodule

// File: rtl/nfold_scale.sv
module nfold_scale #(
   parameter int ACC_W = 9,
   parameter int L     = 5,
   parameter int SHW   = 2
) (
   input  logic signed [ACC_W-1:0] acc_i,
   input  logic [SHW-1:0]          sh_i,
   output logic signed [L:0]       sat_o
);
   localparam int MAXSH = (1 << SHW) - 1;
   localparam int WIDE  = ACC_W + MAXSH;
   localparam logic signed [WIDE-1:0] HI = WIDE'((1 << L) - 1);
   localparam logic signed [WIDE-1:0] LO = ~HI;

   logic signed [WIDE-1:0] wide;

   assign wide  = WIDE'(acc_i) <<< sh_i;
   assign sat_o = (wide > HI) ? HI[L:0] :
                  (wide < LO) ? LO[L:0] : wide[L:0];

   always_comb begin
      if (acc_i > 0) begin
         assert_sign_pos_R7: assert (sat_o > 0)
            else $error("positive total lost its sign after scaling");
      end else if (acc_i < 0) begin
         assert_sign_neg_R7: assert (sat_o < 0)
            else $error("negative total lost its sign after scaling");
      end
   end
endmodule

// File: rtl/nfold_neuron_acc.sv
module nfold_neuron_acc #(
   parameter int N     = 3,
   parameter int L     = 5,
   parameter int M     = 4,
   parameter int PIPE  = 1,
   parameter int GUARD = 3,
   parameter int SHW   = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 pass_vld_i,
   input  logic                 pass_first_i,
   input  logic                 pass_last_i,
   input  logic [M-1:0]         lane_en_i,
   input  logic [M*(N+1)-1:0]   x_i,
   input  logic [M*(N+1)-1:0]   w_i,
   input  logic signed [L:0]    bias_i,
   input  logic [SHW-1:0]       shift_i,
   output logic signed [L:0]    sum_o,
   output logic                 sum_vld_o
);
   import nfold_pkg::*;

   localparam int W      = N + 1;
   localparam int ACC_W  = L + 1 + GUARD;
   localparam int LEVELS = $clog2(M);
   localparam int SBW    = $bits(pass_ctl_t) + L + 1 + SHW;

   if (L < N || L > 2*N) begin : g_bad_l
      $error("L must lie between N and 2N");
   end
   if ((1 << LEVELS) != M) begin : g_bad_m
      $error("M must be a power of two");
   end
   if (PIPE < 0 || PIPE > LEVELS) begin : g_bad_pipe
      $error("PIPE must lie between 0 and log2(M)");
   end
   if (GUARD < LEVELS) begin : g_bad_guard
      $error("GUARD must cover the adder tree growth");
   end

   logic signed [ACC_W-1:0] prod [M];
   logic signed [ACC_W-1:0] tree_sum;
   logic [SBW-1:0]          side_in, side_out;
   pass_ctl_t               ctl_in, d_ctl;
   logic signed [L:0]       d_bias;
   logic [SHW-1:0]          d_sh;
   logic signed [ACC_W-1:0] acc_q, acc_base, acc_next;
   logic signed [L:0]       scaled;

   for (genvar i = 0; i < M; i++) begin : g_lane
      nfold_lane #(.N(N), .L(L), .ACC_W(ACC_W)) u_lane (
         .en_i   (lane_en_i[i]),
         .x_i    (x_i[i*W +: W]),
         .w_i    (w_i[i*W +: W]),
         .prod_o (prod[i])
      );
   end

   assign ctl_in  = {pass_vld_i, pass_first_i, pass_last_i};
   assign side_in = {ctl_in, bias_i, shift_i};

   nfold_tree #(.M(M), .ACC_W(ACC_W), .PIPE(PIPE), .SBW(SBW)) u_tree (
      .clk    (clk),
      .rst    (rst),
      .prod_i (prod),
      .side_i (side_in),
      .sum_o  (tree_sum),
      .side_o (side_out)
   );

   assign {d_ctl, d_bias, d_sh} = side_out;

   assign acc_base = d_ctl.first ? ACC_W'(d_bias) : acc_q;
   assign acc_next = acc_base + tree_sum;

   nfold_scale #(.ACC_W(ACC_W), .L(L), .SHW(SHW)) u_scale (
      .acc_i (acc_next),
      .sh_i  (d_sh),
      .sat_o (scaled)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q     <= '0;
         sum_o     <= '0;
         sum_vld_o <= 1'b0;
      end else begin
         sum_vld_o <= d_ctl.vld & d_ctl.last;
         if (d_ctl.vld) acc_q <= acc_next;
         if (d_ctl.vld && d_ctl.last) sum_o <= scaled;
      end
   end

   assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !sum_vld_o |-> $stable(sum_o))
      else $error("result changed without a valid strobe");
endmodule

// File: tb/nfold_neuron_acc_tb.sv
module nfold_neuron_acc_tb;
   localparam int N = 3, L = 5, M = 4, PIPE = 1, GUARD = 3, SHW = 2;
   localparam int W = N + 1;
   localparam int MINW = -(1 << N);
   localparam int HI = (1 << L) - 1;
   localparam int LO = -(1 << L);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pass_vld_i = 1'b0, pass_first_i = 1'b0, pass_last_i = 1'b0;
   logic [M-1:0] lane_en_i = '0;
   logic [M*W-1:0] x_i = '0, w_i = '0;
   logic signed [L:0] bias_i = '0;
   logic [SHW-1:0] shift_i = '0;
   logic signed [L:0] sum_o;
   logic sum_vld_o;

   always #5 clk = ~clk;

   nfold_neuron_acc #(.N(N), .L(L), .M(M), .PIPE(PIPE), .GUARD(GUARD), .SHW(SHW)) u_dut (
      .clk(clk), .rst(rst), .pass_vld_i(pass_vld_i), .pass_first_i(pass_first_i),
      .pass_last_i(pass_last_i), .lane_en_i(lane_en_i), .x_i(x_i), .w_i(w_i),
      .bias_i(bias_i), .shift_i(shift_i), .sum_o(sum_o), .sum_vld_o(sum_vld_o));

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int tx[M], tw[M];
   logic [M-1:0] ten;
   int tb, tsh;

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int tprod(int x, int w);
      if (x == MINW && w == MINW) return HI;
      return (x * w) >>> (2*N - L);
   endfunction

   function automatic int lane_sum();
      int s = 0;
      for (int i = 0; i < M; i++) if (ten[i]) s += tprod(tx[i], tw[i]);
      return s;
   endfunction

   function automatic int sat(int v, int sh);
      int t = v * (1 << sh);
      if (t > HI) return HI;
      if (t < LO) return LO;
      return t;
   endfunction

   task automatic drive(bit f, bit l);
      @(negedge clk);
      pass_vld_i = 1'b1; pass_first_i = f; pass_last_i = l;
      lane_en_i = ten;
      for (int i = 0; i < M; i++) begin
         x_i[i*W +: W] = tx[i][W-1:0];
         w_i[i*W +: W] = tw[i][W-1:0];
      end
      bias_i = tb[L:0]; shift_i = tsh[SHW-1:0];
   endtask

   task automatic idle_wait();
      @(negedge clk);
      pass_vld_i = 1'b0; pass_first_i = 1'b0; pass_last_i = 1'b0;
      repeat (PIPE) @(negedge clk);
   endtask

   task automatic finish_check(string tag, int exp);
      idle_wait();
      check(tag, int'(sum_o), exp);
      check({tag, " valid"}, int'(sum_vld_o), 1);
      @(negedge clk);
      check("R6 one-cycle valid", int'(sum_vld_o), 0);
   endtask

   task automatic single(string tag, int exp);
      drive(1, 1);
      finish_check(tag, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int acc, held;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R9: reset state
      check("R9 result", int'(sum_o), 0);
      check("R9 valid", int'(sum_vld_o), 0);

      // R1 / R2 / R3: lane 0 sweep, masked lanes carry nonzero words
      ten = 4'b0001; tb = 0; tsh = 0;
      for (int i = 1; i < M; i++) begin tx[i] = 7; tw[i] = 7; end
      for (int x = MINW; x <= HI >> (L - N); x++) begin
         for (int w = MINW; w < (1 << N); w++) begin
            tx[0] = x; tw[0] = w;
            if (x == MINW && w == MINW) single("R2 min times min", HI);
            else single("R1 lane product", sat(tprod(x, w), 0));
         end
      end

      // R3: all lane masks
      tx = '{3, -5, 7, -8}; tw = '{6, 4, -8, -8}; tb = 2; tsh = 0;
      for (int m = 0; m < (1 << M); m++) begin
         ten = m[M-1:0];
         single("R3 lane mask", sat(tb + lane_sum(), 0));
      end

      // R4 / R11-free single pass: bias sweep
      ten = 4'b0001; tx[0] = 2; tw[0] = 3; tsh = 0;
      for (int b = LO; b <= HI; b++) begin
         tb = b;
         single("R4 bias on first pass", sat(b + lane_sum(), 0));
      end

      // R7: shift and saturation
      for (int p = 0; p < 4; p++) begin
         for (int s = 0; s < (1 << SHW); s++) begin
            tsh = s;
            case (p)
               0: begin ten = 4'b1111; tx = '{7, 7, 7, 7}; tw = '{7, 7, 7, 7}; tb = 31; end
               1: begin ten = 4'b1111; tx = '{-8, -8, -8, -8}; tw = '{7, 7, 7, 7}; tb = -32; end
               2: begin ten = 4'b0001; tx = '{2, 0, 0, 0}; tw = '{2, 0, 0, 0}; tb = 5; end
               default: begin ten = 4'b0001; tx = '{-3, 0, 0, 0}; tw = '{2, 0, 0, 0}; tb = -6; end
            endcase
            single("R7 shift and saturate", sat(tb + lane_sum(), s));
         end
      end

      // R10 / R5 / R6: three passes on consecutive cycles
      for (int k = 0; k < 8; k++) begin
         ten = 4'b1111; tsh = 0;
         tx = '{k - 4, 3, -k, 1}; tw = '{2, -1, 3, k - 3}; tb = 3*k - 10;
         acc = tb + lane_sum();
         drive(1, 0);
         tx = '{5, -k, 2, -7}; tw = '{-2, 1, k - 4, 1}; tb = 31;
         acc += lane_sum();
         drive(0, 0);
         tx = '{-1, 4, k, 6}; tw = '{3, 3, -2, -3}; tb = -32; tsh = k % 4;
         ten = 4'b0111;
         acc += lane_sum();
         drive(0, 1);
         finish_check("R10 back-to-back passes", sat(acc, k % 4));
      end

      // R8 / R5: non-closing pass holds output, then gapped continuation
      held = int'(sum_o);
      ten = 4'b0011; tx = '{4, -2, 0, 0}; tw = '{3, 5, 0, 0}; tb = 7; tsh = 0;
      acc = tb + lane_sum();
      drive(1, 0);
      idle_wait();
      check("R8 no valid on open pass", int'(sum_vld_o), 0);
      check("R8 result holds", int'(sum_o), held);
      repeat (3) @(negedge clk);
      // R11: pass-valid low with strobes and garbage
      @(negedge clk);
      pass_vld_i = 1'b0; pass_first_i = 1'b1; pass_last_i = 1'b1;
      lane_en_i = '1; x_i = '1; w_i = {M*W{1'b1}} >> 1; bias_i = -20; shift_i = 2'd3;
      @(negedge clk);
      pass_first_i = 1'b0; pass_last_i = 1'b0;
      repeat (PIPE + 1) @(negedge clk);
      check("R11 no valid while idle", int'(sum_vld_o), 0);
      check("R11 result untouched", int'(sum_o), held);
      ten = 4'b1000; tx = '{0, 0, 0, 5}; tw = '{0, 0, 0, -6}; tb = -31; tsh = 1;
      acc += lane_sum();
      drive(0, 1);
      finish_check("R5 gapped continuation", sat(acc, 1));

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule